// File: doc/BRIEF.md
# Multiplexed Front-End Readout Sequencer

This block runs the readout of one front-end board. The board carries several shaping-amplifier chips, and each chip puts all of its channels, one after another, onto a single analogue output line. When the block accepts a trigger, it counts a programmable number of fast clock cycles and then raises the sample-and-hold line, so that every shaper output is frozen at its peak. It then walks the analogue multiplexer through each channel of each chip, strobes an external ADC once per channel, and sends every converted sample downstream on a valid/ready stream. Each word on that stream is tagged with its chip and channel index.

The fast clock sets the resolution of the hold delay. At a 100 MHz clock the delay moves in 10 ns steps, and a setting of 18 puts the hold near the nominal 180 ns shaper peak. The multiplexer runs on a slower programmable slot period, since its edges only need coarse accuracy. The ADC strobe sits in the middle of each slot, after the multiplexer has had time to settle. In calibration mode the block sends a one-cycle charge-injection strobe before the hold, and the same readout sequence then returns the injected signal. A trigger that arrives while the block is busy has no effect.

Top module: `fe_readout_seq`

## Requirements
- R1: After reset, busy_o, hold_o, calib_o, adc_strobe_o and out_valid_o are low, and mux_chip_o and mux_chan_o are 0.
- R2: If trig_i is high at a clock edge while busy_o is low, the trigger is accepted at that edge and busy_o is high from that edge on.
- R3: hold_o rises exactly hold_dly_i clock edges after the edge that accepted the trigger. The delay is latched at acceptance, and a value of 0 acts as 1.
- R4: If calib_en_i is high when the trigger is accepted, calib_o is high for exactly the one cycle that follows the accepting edge. Otherwise calib_o stays low.
- R5: Each event reads all 6 x 18 = 108 slots, with exactly one ADC strobe per slot. The order is chip-major: channels 0 to 17 of chip 0, then chip 1, and so on up to chip 5.
- R6: Each slot lasts chan_period_i cycles, latched at acceptance, and a value below 2 acts as 2. The strobe is a one-cycle pulse at slot phase period/2. The first strobe therefore comes period/2 edges after hold_o rises, and when the stream is not stalled, consecutive strobes are exactly one period apart.
- R7: Each output word carries the chip index in out_data_o[21:19], the channel index in out_data_o[18:14], and in out_data_o[13:0] the adc_data_i value present during that slot's strobe cycle.
- R8: out_last_o is high only with the final word of the event (chip 5, channel 17).
- R9: While out_valid_o is high and out_ready_i is low, the word and its last flag stay unchanged and no new strobe is issued. The sequence resumes once the word is taken.
- R10: hold_o stays high through every strobe of the event. It falls at the edge that captures the final sample, so it is already low when the last word appears.
- R11: busy_o stays high until the last word is accepted and falls at that edge. Triggers that arrive while busy_o is high start no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sequencing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger request |
| calib_en_i | input | 1 | Fire the charge-injection strobe for the next event |
| hold_dly_i | input | 8 | Trigger-to-hold delay in clock cycles |
| chan_period_i | input | 6 | Clock cycles per multiplexer slot |
| adc_data_i | input | 14 | Converted sample from the external ADC |
| adc_strobe_o | output | 1 | ADC conversion strobe, one per slot |
| mux_chip_o | output | 3 | Chip currently selected on the multiplexer |
| mux_chan_o | output | 5 | Channel currently selected on the multiplexer |
| hold_o | output | 1 | Sample-and-hold control |
| calib_o | output | 1 | Charge-injection strobe |
| busy_o | output | 1 | Event in progress |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 22 | Chip, channel and sample |
| out_last_o | output | 1 | Final word of the event |

## Verification
The assertions check, on every cycle, the rules that link neighbouring cycles. Each of the following is checked as it happens:
- hold_o is high whenever a strobe fires, and busy_o is high whenever hold_o is.
- calib_o is a single-cycle pulse.
- A stalled word stays frozen, and no strobe fires while it waits.
- busy_o falls right after the last handshake.
- An idle trigger raises busy.

Other behaviours only show up in the bench's scenarios, because they need the history of a whole event: the exact hold delay, including the clamped zero setting; the offset of the first strobe and the spacing between strobes; the clamp on the slot period; the chip-major order; and the match between sample and tag, which the scoreboard checks across 108 words under free-running, random and heavily stalled ready patterns. The same applies to showing that a mid-event trigger is dropped.

// File: rtl/fe_readout_pkg.sv
package fe_readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CONV,
    ST_DRAIN
  } seq_state_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fe_hold_timer.sv
module fe_hold_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);
  logic             active_q;
  logic [DLY_W-1:0] cnt_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dly_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= DLY_W'(1);
      dly_q    <= (dly_i == '0) ? DLY_W'(1) : dly_i;
    end else if (active_q) begin
      if (cnt_q == dly_q) active_q <= 1'b0;
      else                cnt_q    <= cnt_q + 1'b1;
    end
  end

  // fires on the edge that is dly cycles after the start edge
  assign done_o = active_q && (cnt_q == dly_q);
endmodule

// File: rtl/fe_chan_stepper.sv
module fe_chan_stepper
  import fe_readout_pkg::*;
#(
  parameter int N_CHIPS = 6,
  parameter int N_CHANS = 18,
  parameter int PER_W   = 6,
  localparam int CHIP_W = idx_w(N_CHIPS),
  localparam int CHAN_W = idx_w(N_CHANS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              stall_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [CHIP_W-1:0] chip_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              strobe_o,
  output logic              last_o
);
  logic [PER_W-1:0]  per_q, ph_q, strobe_ph;
  logic [CHIP_W-1:0] chip_q;
  logic [CHAN_W-1:0] chan_q;
  logic              at_strobe, last_chan, last_chip;

  assign strobe_ph = per_q >> 1;
  assign at_strobe = run_i && (ph_q == strobe_ph);
  assign last_chan = (chan_q == CHAN_W'(N_CHANS - 1));
  assign last_chip = (chip_q == CHIP_W'(N_CHIPS - 1));
  assign strobe_o  = at_strobe && !stall_i;
  assign last_o    = strobe_o && last_chan && last_chip;
  assign chip_o    = chip_q;
  assign chan_o    = chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= PER_W'(2);
      ph_q   <= '0;
      chip_q <= '0;
      chan_q <= '0;
    end else if (clear_i) begin
      per_q  <= (period_i < PER_W'(2)) ? PER_W'(2) : period_i;
      ph_q   <= '0;
      chip_q <= '0;
      chan_q <= '0;
    end else if (run_i && !(at_strobe && stall_i)) begin
      if (ph_q == per_q - 1'b1) begin
        ph_q <= '0;
        if (last_chan) begin
          chan_q <= '0;
          chip_q <= last_chip ? '0 : chip_q + 1'b1;
        end else begin
          chan_q <= chan_q + 1'b1;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fe_out_stage.sv
module fe_out_stage #(
  parameter int W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         load_last_i,
  input  logic [W-1:0] din_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic         last_o,
  output logic [W-1:0] data_o,
  output logic         stall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      last_o  <= load_last_i;
      data_o  <= din_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign stall_o = valid_o && !ready_i;
endmodule

// File: rtl/fe_readout_seq.sv
module fe_readout_seq
  import fe_readout_pkg::*;
#(
  parameter int N_CHIPS = 6,
  parameter int N_CHANS = 18,
  parameter int DATA_W  = 14,
  parameter int DLY_W   = 8,
  parameter int PER_W   = 6,
  localparam int CHIP_W = idx_w(N_CHIPS),
  localparam int CHAN_W = idx_w(N_CHANS),
  localparam int WORD_W = CHIP_W + CHAN_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              calib_en_i,
  input  logic [DLY_W-1:0]  hold_dly_i,
  input  logic [PER_W-1:0]  chan_period_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_strobe_o,
  output logic [CHIP_W-1:0] mux_chip_o,
  output logic [CHAN_W-1:0] mux_chan_o,
  output logic              hold_o,
  output logic              calib_o,
  output logic              busy_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_last_o
);
  seq_state_e state_q;
  logic accept, hold_done, strobe, last_strobe, stall;

  assign accept = (state_q == ST_IDLE) && trig_i;

  fe_hold_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .dly_i   (hold_dly_i),
    .done_o  (hold_done)
  );

  fe_chan_stepper #(
    .N_CHIPS (N_CHIPS),
    .N_CHANS (N_CHANS),
    .PER_W   (PER_W)
  ) u_stepper (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .run_i    (state_q == ST_CONV),
    .stall_i  (stall),
    .period_i (chan_period_i),
    .chip_o   (mux_chip_o),
    .chan_o   (mux_chan_o),
    .strobe_o (strobe),
    .last_o   (last_strobe)
  );

  fe_out_stage #(.W(WORD_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (strobe),
    .load_last_i (last_strobe),
    .din_i       ({mux_chip_o, mux_chan_o, adc_data_i}),
    .ready_i     (out_ready_i),
    .valid_o     (out_valid_o),
    .last_o      (out_last_o),
    .data_o      (out_data_o),
    .stall_o     (stall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_o  <= 1'b0;
      calib_o <= 1'b0;
    end else begin
      calib_o <= accept && calib_en_i;
      unique case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_WAIT;
        ST_WAIT:  if (hold_done) begin
                    hold_o  <= 1'b1;
                    state_q <= ST_CONV;
                  end
        ST_CONV:  if (last_strobe) begin
                    hold_o  <= 1'b0;  // release only after the final slot is sampled
                    state_q <= ST_DRAIN;
                  end
        ST_DRAIN: if (out_valid_o && out_ready_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign adc_strobe_o = strobe;
endmodule

// File: rtl/fe_readout_seq_chk.sv
module fe_readout_seq_chk #(
  parameter int W = 22
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         trig_i,
  input logic         busy_o,
  input logic         hold_o,
  input logic         calib_o,
  input logic         adc_strobe_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic         out_last_o,
  input logic [W-1:0] out_data_o
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trig_i) |=> busy_o);

  p_calib_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calib_o |=> !calib_o);

  p_stall_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  p_no_strobe_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !adc_strobe_o);

  p_hold_on_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_strobe_o |-> hold_o);

  p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> busy_o);

  p_busy_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> !busy_o);
endmodule

bind fe_readout_seq fe_readout_seq_chk #(.W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_i       (trig_i),
  .busy_o       (busy_o),
  .hold_o       (hold_o),
  .calib_o      (calib_o),
  .adc_strobe_o (adc_strobe_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_last_o   (out_last_o),
  .out_data_o   (out_data_o)
);

// File: tb/fe_readout_seq_tb.sv
module fe_readout_seq_tb;
  localparam int NC = 6, NH = 18, WW = 22;

  logic        clk = 1'b0, rst_n = 1'b0, trig = 1'b0, calib_en = 1'b0;
  logic [7:0]  dly = 8'd18;
  logic [5:0]  per = 6'd8;
  logic [13:0] adc;
  logic        ready = 1'b1;
  logic        strobe, hold, calib, busy, valid, last;
  logic [2:0]  chip;
  logic [4:0]  chan;
  logic [WW-1:0] data;

  int checks = 0, fails = 0, cyc = 0;
  int mode = 0, strobe_n = 0, last_strobe_cyc = 0, exp_gap = 8;
  bit gap_en = 0, busy_pend = 0, prev_stall = 0;
  logic [WW-1:0] prev_data;
  logic [15:0] seed = 16'h0, lfsr = 16'hace1;
  logic [WW:0] exp_q[$];

  fe_readout_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .calib_en_i(calib_en),
    .hold_dly_i(dly), .chan_period_i(per), .adc_data_i(adc),
    .adc_strobe_o(strobe), .mux_chip_o(chip), .mux_chan_o(chan),
    .hold_o(hold), .calib_o(calib), .busy_o(busy),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(data), .out_last_o(last)
  );

  always #10 clk = ~clk;

  function automatic logic [13:0] sample(input int c, input int h, input logic [15:0] s);
    return 14'((int'(s) * 7 + c * 1000 + h * 53 + 5) & 16'h3fff);
  endfunction

  // ADC model: valid sample only during the strobe cycle
  assign adc = strobe ? sample(int'(chip), int'(chan), seed) : 14'h1555;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #3;
    ready <= (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : ((cyc % 25) == 0);
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_pend) begin
        chk(!busy, "R11", int'(busy), 0);
        busy_pend = 0;
      end
      if (prev_stall) chk(valid && data == prev_data, "R9", int'(data), int'(prev_data));
      if (valid && !ready) chk(!strobe, "R9", int'(strobe), 0);
      prev_stall = valid && !ready;
      prev_data  = data;
      if (strobe) begin
        chk(hold, "R10", int'(hold), 1);
        if (gap_en && strobe_n > 0) chk(cyc - last_strobe_cyc == exp_gap, "R6",
                                        cyc - last_strobe_cyc, exp_gap);
        strobe_n++;
        last_strobe_cyc = cyc;
      end
      if (valid && ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5", int'(data), -1);
        end else begin
          logic [WW:0] e;
          e = exp_q.pop_front();
          chk(data[21:14] == e[21:14], "R5", int'(data[21:14]), int'(e[21:14]));
          chk(data[13:0] == e[13:0], "R7", int'(data[13:0]), int'(e[13:0]));
          chk(last == e[WW], "R8", int'(last), int'(e[WW]));
          if (e[WW]) begin
            chk(!hold, "R10", int'(hold), 0);
            busy_pend = 1;
          end
        end
      end
    end
  end

  task automatic run_event(input int d, input int p, input bit c, input logic [15:0] s,
                           input int m, input bit g, input bit mid_trig);
    int n, n2, eff_p, eff_d;
    eff_p = (p < 2) ? 2 : p;
    eff_d = (d == 0) ? 1 : d;
    @(negedge clk);
    seed = s; dly = 8'(d); per = 6'(p); calib_en = c; mode = m;
    gap_en = g; exp_gap = eff_p; strobe_n = 0;
    for (int ci = 0; ci < NC; ci++)
      for (int hi = 0; hi < NH; hi++)
        exp_q.push_back({(ci == NC - 1 && hi == NH - 1), 3'(ci), 5'(hi), sample(ci, hi, s)});
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(busy, "R2", int'(busy), 1);
    chk(calib == c, "R4", int'(calib), int'(c));
    n = 0;
    while (!hold) begin
      @(negedge clk);
      n++;
      if (n == 1) chk(!calib, "R4", int'(calib), 0);
    end
    chk(n == eff_d, "R3", n, eff_d);
    n2 = 0;
    while (!strobe) begin
      @(negedge clk);
      n2++;
    end
    chk(n2 == eff_p / 2, "R6", n2, eff_p / 2);
    if (mid_trig) begin
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(strobe_n == NC * NH, "R5", strobe_n, NC * NH);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    chk(!busy && !hold && !valid, "R11", int'({busy, hold, valid}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !calib && !strobe && !valid, "R1",
        int'({busy, hold, calib, strobe, valid}), 0);
    chk(chip == 0 && chan == 0, "R1", int'({chip, chan}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !valid, "R1", int'({busy, valid}), 0);
    run_event(18, 8, 1'b0, 16'h0123, 0, 1'b1, 1'b0);
    run_event(5, 3, 1'b1, 16'h4567, 1, 1'b0, 1'b0);
    run_event(0, 1, 1'b0, 16'h89ab, 0, 1'b1, 1'b0);
    run_event(30, 8, 1'b1, 16'hcdef, 2, 1'b0, 1'b1);
    finish_run();
  end
endmodule